// File: doc/BRIEF.md
# Command-Fetching I/O Processor

This block takes data transfers off the host. The host hands it a short instruction made of an operation code, a device number and the memory address of a command block. The processor then reads the four-word command block from memory on its own, decodes it, and moves a block of words between the selected device and memory. It takes the memory bus one word at a time, so the host's own accesses can fit in between. When the command is finished, it raises an interrupt that stays high until the host acknowledges it.

The memory side is a single-port request/grant bus with read data returned later. Only one access is outstanding at a time. The device side has a one-cycle pop strobe, which takes a word from the device, and a one-cycle push strobe, which gives a word to it. The device number and the command's special-request word are presented to the device while a command is in flight.

Top module: `iop_core`

## Requirements
- R1: After reset the block is idle: `cmd_ready_o` is 1, and `mem_req_o`, `dev_pop_o`, `dev_push_o`, `irq_o` and `err_o` are 0.
- R2: A host instruction is accepted when `cmd_valid_i` and `cmd_ready_o` are both high. Operation code 1 starts a command: the block reads four words at `cmd_addr_i`+0, +1, +2, +3, in that order, before it moves any data. Any other host operation code is dropped. A dropped instruction makes no memory access and raises no interrupt.
- R3: The command block holds the command code at word 0, the buffer address at word 1 (low AW bits), the word count at word 2 (low CW bits) and the special-request word at word 3. While the command runs, `dev_sel_o` equals the instruction's device number and `dev_flags_o` equals word 3.
- R4: Command code 0 (device to memory) pops `count` words from the device and writes them to buffer address, buffer address+1, and so on, in pop order.
- R5: Command code 1 (memory to device) reads `count` words starting at the buffer address and pushes them to the device in address order.
- R6: Any command code other than 0 or 1 ends the command after the four-word fetch. The interrupt rises with `err_o` set, and no data cycles take place.
- R7: A count of zero ends the command after the fetch. The interrupt rises with `err_o` clear, and no data cycles take place.
- R8: After each data word, the block drops `mem_req_o` for at least one cycle. `mem_req_o` is low in the cycle after a write grant and whenever `dev_push_o` or `dev_pop_o` is high.
- R9: Once `mem_req_o` is raised, it stays high, with `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged, until `mem_gnt_i` is seen.
- R10: `irq_o` stays high until `irq_ack_i`, and both `irq_o` and `err_o` clear on the acknowledge. `cmd_ready_o` is low from acceptance until the acknowledge. `err_o` is never high without `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Host instruction valid |
| cmd_ready_o | output | 1 | Block idle, instruction can be taken |
| cmd_op_i | input | OPW | Host operation code (1 = run) |
| cmd_dev_i | input | DEVW | Target device number |
| cmd_addr_i | input | AW | Memory address of command block |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| dev_sel_o | output | DEVW | Selected device |
| dev_flags_o | output | DW | Special-request word of current command |
| dev_pop_o | output | 1 | Take one word from the device |
| dev_rdata_i | input | DW | Device word, sampled while popping |
| dev_push_o | output | 1 | Give one word to the device |
| dev_wdata_o | output | DW | Word pushed to the device |
| irq_o | output | 1 | Command complete interrupt |
| irq_ack_i | input | 1 | Host acknowledge of interrupt |
| err_o | output | 1 | Command ended on an unknown command code |

## Verification
The checks assume that the memory returns `mem_rvalid_i` only after a read grant, and only once per grant. They also assume that `irq_ack_i` is raised only while `irq_o` is high, and that `cmd_valid_i` is dropped once the instruction has been taken. The bench's memory model keeps to these rules. It grants requests after a random wait and returns read data after a random latency of zero to two cycles. It asserts the acknowledge only after it has seen the interrupt. Random commands keep their command blocks and buffers in separate address ranges, so a data write can never overwrite a command word that is still to be fetched.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_DECODE, ST_POP, ST_WREQ,
    ST_RREQ, ST_RWAIT, ST_PUSH, ST_YIELD, ST_DONE
  } iop_state_e;

  localparam int unsigned CB_WORDS = 4;
  localparam int unsigned CB_IDX_W = $clog2(CB_WORDS);
  // command block word positions, fetched in this order
  localparam int unsigned W_CODE = 0;
  localparam int unsigned W_BUF  = 1;
  localparam int unsigned W_CNT  = 2;
  localparam int unsigned W_SPC  = 3;
  localparam int unsigned HOST_RUN = 1;
  localparam int unsigned CODE_D2M = 0;
  localparam int unsigned CODE_M2D = 1;
endpackage

// File: rtl/iop_cmd_store.sv
module iop_cmd_store
  import iop_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [CB_IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]       wr_word_i,
  output logic [DW-1:0]       code_o,
  output logic [DW-1:0]       buf_o,
  output logic [DW-1:0]       cnt_o,
  output logic [DW-1:0]       spc_o
);
  logic [DW-1:0] words_q [CB_WORDS];

  for (genvar g = 0; g < CB_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   words_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == CB_IDX_W'(g))  words_q[g] <= wr_word_i;
    end
  end

  assign code_o = words_q[W_CODE];
  assign buf_o  = words_q[W_BUF];
  assign cnt_o  = words_q[W_CNT];
  assign spc_o  = words_q[W_SPC];
endmodule

// File: rtl/iop_xfer_ctr.sv
module iop_xfer_ctr #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      left_q <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      left_q <= left_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == CW'(1));
endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned DW   = 32,
  parameter int unsigned DEVW = 4,
  parameter int unsigned OPW  = 4,
  parameter int unsigned CW   = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  output logic            cmd_ready_o,
  input  logic [OPW-1:0]  cmd_op_i,
  input  logic [DEVW-1:0] cmd_dev_i,
  input  logic [AW-1:0]   cmd_addr_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_gnt_i,
  input  logic            mem_rvalid_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DEVW-1:0] dev_sel_o,
  output logic [DW-1:0]   dev_flags_o,
  output logic            dev_pop_o,
  input  logic [DW-1:0]   dev_rdata_i,
  output logic            dev_push_o,
  output logic [DW-1:0]   dev_wdata_o,
  output logic            irq_o,
  input  logic            irq_ack_i,
  output logic            err_o
);
  iop_state_e state_q, state_d;
  logic [CB_IDX_W-1:0] idx_q;
  logic [AW-1:0]       base_q;
  logic [DEVW-1:0]     dev_q;
  logic [DW-1:0]       data_q;
  logic                err_q, m2d_q;

  logic [DW-1:0] code_w, buf_w, cnt_w, spc_w;
  logic          accept, run, fetch_wr, code_d2m, code_m2d, cnt_zero;
  logic          ctr_load, ctr_step, ctr_last;
  logic [AW-1:0] ctr_addr;

  assign accept   = cmd_valid_i && (state_q == ST_IDLE);
  assign run      = accept && (cmd_op_i == OPW'(HOST_RUN));
  assign fetch_wr = (state_q == ST_FWAIT) && mem_rvalid_i;
  assign code_d2m = (code_w == DW'(CODE_D2M));
  assign code_m2d = (code_w == DW'(CODE_M2D));
  assign cnt_zero = (cnt_w[CW-1:0] == '0);
  assign ctr_load = (state_q == ST_DECODE);
  assign ctr_step = (state_q == ST_YIELD);

  iop_cmd_store #(.DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (fetch_wr),
    .wr_idx_i  (idx_q),
    .wr_word_i (mem_rdata_i),
    .code_o    (code_w),
    .buf_o     (buf_w),
    .cnt_o     (cnt_w),
    .spc_o     (spc_w)
  );

  iop_xfer_ctr #(.AW(AW), .CW(CW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctr_load),
    .base_i (buf_w[AW-1:0]),
    .cnt_i  (cnt_w[CW-1:0]),
    .step_i (ctr_step),
    .addr_o (ctr_addr),
    .last_o (ctr_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (run) state_d = ST_FREQ;
      ST_FREQ:   if (mem_gnt_i) state_d = ST_FWAIT;
      ST_FWAIT:  if (mem_rvalid_i)
                   state_d = (idx_q == CB_IDX_W'(CB_WORDS - 1)) ? ST_DECODE : ST_FREQ;
      ST_DECODE: begin
        if (!(code_d2m || code_m2d) || cnt_zero) state_d = ST_DONE;
        else if (code_m2d)                       state_d = ST_RREQ;
        else                                     state_d = ST_POP;
      end
      ST_POP:    state_d = ST_WREQ;
      ST_WREQ:   if (mem_gnt_i) state_d = ST_YIELD;
      ST_RREQ:   if (mem_gnt_i) state_d = ST_RWAIT;
      ST_RWAIT:  if (mem_rvalid_i) state_d = ST_PUSH;
      ST_PUSH:   state_d = ST_YIELD;
      ST_YIELD: begin
        if (ctr_last)   state_d = ST_DONE;
        else if (m2d_q) state_d = ST_RREQ;
        else            state_d = ST_POP;
      end
      ST_DONE:   if (irq_ack_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      dev_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      m2d_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (run) begin
        idx_q  <= '0;
        base_q <= cmd_addr_i;
        dev_q  <= cmd_dev_i;
      end
      if (fetch_wr) idx_q <= idx_q + CB_IDX_W'(1);
      if (state_q == ST_DECODE) begin
        err_q <= !(code_d2m || code_m2d);
        m2d_q <= code_m2d;
      end
      if (state_q == ST_DONE && irq_ack_i) err_q <= 1'b0;
      if (state_q == ST_POP) data_q <= dev_rdata_i;
      if (state_q == ST_RWAIT && mem_rvalid_i) data_q <= mem_rdata_i;
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FREQ) || (state_q == ST_WREQ) || (state_q == ST_RREQ);
  assign mem_we_o    = (state_q == ST_WREQ);
  assign mem_addr_o  = (state_q == ST_FREQ) ? base_q + AW'(idx_q) : ctr_addr;
  assign mem_wdata_o = data_q;
  assign dev_sel_o   = dev_q;
  assign dev_flags_o = spc_w;
  assign dev_pop_o   = (state_q == ST_POP);
  assign dev_push_o  = (state_q == ST_PUSH);
  assign dev_wdata_o = data_q;
  assign irq_o       = (state_q == ST_DONE);
  assign err_o       = err_q;
endmodule

// File: rtl/iop_core_chk.sv
module iop_core_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_ready_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_gnt_i,
  input logic          dev_pop_o,
  input logic          dev_push_o,
  input logic          irq_o,
  input logic          irq_ack_i,
  input logic          err_o
);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o)
                                 && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_yield_after_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && mem_we_o |=> !mem_req_o);

  assert_strobe_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, dev_pop_o, dev_push_o}));

  assert_irq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_ack_i |=> irq_o);

  assert_irq_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && irq_ack_i |=> !irq_o && !err_o);

  assert_err_with_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> irq_o);

  assert_ready_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !irq_o && !mem_req_o);
endmodule

bind iop_core iop_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_ready_o (cmd_ready_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_gnt_i   (mem_gnt_i),
  .dev_pop_o   (dev_pop_o),
  .dev_push_o  (dev_push_o),
  .irq_o       (irq_o),
  .irq_ack_i   (irq_ack_i),
  .err_o       (err_o)
);

// File: tb/tb_iop_core.sv
`timescale 1ns/1ps
module tb_iop_core;
  localparam int AW = 16, DW = 32, DEVW = 4, OPW = 4, CW = 16, MW = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [OPW-1:0] cmd_op = '0;
  logic [DEVW-1:0] cmd_dev = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic mem_req, mem_we, gnt = 0, rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rdata = '0;
  logic [DEVW-1:0] dev_sel;
  logic [DW-1:0] dev_flags, dev_rdata = '0, dev_wdata;
  logic dev_pop, dev_push, irq, irq_ack = 0, err;

  iop_core #(.AW(AW), .DW(DW), .DEVW(DEVW), .OPW(OPW), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_dev_i(cmd_dev), .cmd_addr_i(cmd_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_gnt_i(gnt), .mem_rvalid_i(rvalid),
    .mem_rdata_i(rdata), .dev_sel_o(dev_sel), .dev_flags_o(dev_flags),
    .dev_pop_o(dev_pop), .dev_rdata_i(dev_rdata), .dev_push_o(dev_push),
    .dev_wdata_o(dev_wdata), .irq_o(irq), .irq_ack_i(irq_ack), .err_o(err)
  );

  logic [DW-1:0] mem [MW];
  logic [DW-1:0] src [64];
  logic [DW-1:0] sink [64];
  int n_chk = 0, n_fail = 0;
  int pop_n, push_n, acc_n, sel_bad, yield_bad, hold_bad;
  logic [DEVW-1:0] exp_dev;
  logic [DW-1:0] exp_spc;

  // memory and device model: all activity at the falling edge
  initial begin
    bit hs, hs_we, pop_seen, rd_pend, req_wait;
    logic [AW-1:0] hs_addr, rd_addr, wait_addr;
    logic [DW-1:0] hs_wdata;
    int rd_lat;
    hs = 0; pop_seen = 0; rd_pend = 0; req_wait = 0; rd_lat = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        gnt = 0; rvalid = 0; hs = 0; rd_pend = 0; req_wait = 0;
        continue;
      end
      if (pop_seen) pop_n++;
      pop_seen = dev_pop;
      dev_rdata = src[pop_n % 64];
      if (dev_pop && (dev_sel !== exp_dev || dev_flags !== exp_spc)) sel_bad++;
      if (dev_push) begin
        if (dev_sel !== exp_dev || dev_flags !== exp_spc) sel_bad++;
        sink[push_n % 64] = dev_wdata;
        push_n++;
      end
      if (req_wait && !(mem_req && mem_addr == wait_addr)) hold_bad++;
      rvalid = 0;
      if (hs) begin
        acc_n++;
        if (hs_we) begin
          mem[hs_addr[7:0]] = hs_wdata;
          if (mem_req) yield_bad++;
        end else begin
          rd_pend = 1; rd_addr = hs_addr; rd_lat = $urandom % 3;
        end
      end
      if (rd_pend) begin
        if (rd_lat == 0) begin
          rvalid = 1; rdata = mem[rd_addr[7:0]]; rd_pend = 0;
        end else rd_lat--;
      end
      gnt = mem_req && (($urandom % 3) != 0);
      hs = gnt;
      req_wait = mem_req && !gnt;
      wait_addr = mem_addr;
      hs_we = mem_we; hs_addr = mem_addr; hs_wdata = mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [DW-1:0] code);
    return code > 1;
  endfunction

  function automatic int exp_acc(input logic [DW-1:0] code, input int cnt);
    return (exp_err(code) || cnt == 0) ? 4 : 4 + cnt;
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic run_cmd(input logic [OPW-1:0] hop, input logic [DEVW-1:0] dev,
                         input int base, input logic [DW-1:0] code, input int baddr,
                         input int cnt, input logic [DW-1:0] spc);
    logic [DW-1:0] expb [64];
    int w;
    tick();
    mem[base] = code; mem[base+1] = DW'(baddr); mem[base+2] = DW'(cnt); mem[base+3] = spc;
    for (int i = 0; i < 64; i++) begin
      src[i] = $urandom;
      sink[i] = '0;
      expb[i] = $urandom;
      if (baddr + i < MW) mem[baddr+i] = expb[i];
    end
    pop_n = 0; push_n = 0; acc_n = 0; sel_bad = 0; yield_bad = 0; hold_bad = 0;
    exp_dev = dev; exp_spc = spc;
    w = 0;
    while (!cmd_ready && w < 100) begin tick(); w++; end
    cmd_valid = 1; cmd_op = hop; cmd_dev = dev; cmd_addr = AW'(base);
    tick();
    cmd_valid = 0;
    if (hop != 1) begin
      repeat (20) tick();
      chk(acc_n == 0 && !irq && cmd_ready, "R2 dropped host op", acc_n, 0);
      return;
    end
    w = 0;
    while (!irq && w < 3000) begin tick(); w++; end
    chk(irq, "R10 irq raised", irq, 1);
    chk(err == exp_err(code), exp_err(code) ? "R6 error flag" : "R7 error flag", err, exp_err(code));
    chk(acc_n == exp_acc(code, cnt), "R2 R6 R7 access count", acc_n, exp_acc(code, cnt));
    if (!exp_err(code) && code == 0) begin
      chk(pop_n == cnt, "R4 pop count", pop_n, cnt);
      for (int i = 0; i < cnt; i++)
        chk(mem[baddr+i] == src[i], "R4 memory word", mem[baddr+i], src[i]);
    end else if (!exp_err(code)) begin
      chk(push_n == cnt, "R5 push count", push_n, cnt);
      for (int i = 0; i < cnt; i++)
        chk(sink[i] == expb[i], "R5 device word", sink[i], expb[i]);
    end else begin
      chk(pop_n == 0 && push_n == 0, "R6 no data", pop_n + push_n, 0);
    end
    chk(sel_bad == 0, "R3 device select and flags", sel_bad, 0);
    chk(yield_bad == 0, "R8 bus yield", yield_bad, 0);
    chk(hold_bad == 0, "R9 request hold", hold_bad, 0);
    repeat (3) tick();
    chk(irq && !cmd_ready, "R10 irq held", irq, 1);
    irq_ack = 1;
    tick();
    irq_ack = 0;
    chk(!irq && !err && cmd_ready, "R10 ack clears", {irq, err, cmd_ready}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_dev = '0; exp_spc = '0;
    for (int i = 0; i < MW; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    tick();
    chk(cmd_ready && !mem_req && !dev_pop && !dev_push && !irq && !err, "R1 reset state",
        {cmd_ready, mem_req, dev_pop, dev_push, irq, err}, 6'b100000);
    run_cmd(1, 4'h3, 8,  0, 100, 3, 32'hA5A5_0001);
    run_cmd(1, 4'h9, 20, 1, 120, 5, 32'h0000_BEEF);
    run_cmd(1, 4'h1, 0,  0, 80,  0, 32'h1);
    run_cmd(1, 4'h2, 4,  7, 90,  4, 32'h2);
    run_cmd(0, 4'h5, 12, 0, 70,  2, 32'h3);
    run_cmd(5, 4'h6, 16, 1, 70,  2, 32'h4);
    run_cmd(1, 4'hF, 32, 0, 200, 1, 32'h5);
    run_cmd(1, 4'h0, 36, 1, 201, 1, 32'h6);
    for (int k = 0; k < 20; k++) begin
      int sel;
      logic [DW-1:0] code;
      sel = $urandom % 8;
      code = (sel == 0) ? DW'(2 + $urandom % 5) : DW'(sel % 2);
      run_cmd(1, DEVW'($urandom), $urandom % 40, code, 64 + $urandom % 120,
              1 + $urandom % 16, $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule